// File: doc/BRIEF.md
# Edge-Interrupt GPIO Controller

This block is a register-mapped bank of general-purpose I/O lines. Each line has its own settings. A direction bit chooses whether the line is driven or sampled. A drive-mode bit is passed to the pad as an open-drain request. An input-buffer bit decides whether the sampled pad value enters the core at all. Software reaches the registers over a plain single-cycle write / combinational read bus with byte addresses and 32-bit words.

Each input pad goes through a two-flop synchronizer. After that, the block compares the buffered value with its copy from one cycle earlier to find transitions. A per-line control bit picks the capture rule: falling edges only, or any change. Captured transitions are held in sticky event bits. Software clears an event bit by writing 1 to it. One interrupt line goes high while any event bit is set and its mask bit is also set.

Register bits are numbered the opposite way from lines. Line n sits at register bit 31−n in every register. Pad vectors are indexed by line.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: Word offsets select the registers: 0x00 direction, 0x04 drive mode, 0x08 data, 0x0C event, 0x10 mask, 0x14 capture control, 0x18 input-buffer enable. The direction, drive mode, mask, control and buffer registers read back the value last written. Any other address, including one with a non-zero low byte offset, reads 0 and a write to it changes nothing.
- R2: Line n maps to register bit 31−n. pad_out[n] carries data bit 31−n, and pad_od[n] carries drive-mode bit 31−n.
- R3: pad_oe[n] is 1 exactly when direction bit 31−n is 1. A 1 in the direction register makes the line an output.
- R4: Writing the event register clears every event bit written as 1 and leaves every bit written as 0 unchanged.
- R5: irq is 1 exactly when some bit is 1 in both the event register and the mask register.
- R6: When a line's control bit is 1, only a 1→0 transition of its buffered input sets its event bit. When the control bit is 0, both transitions set it. Event bits stay set until they are cleared.
- R7: When a line's input-buffer bit is 0, its buffered input reads as 0. That line's pad therefore neither shows in the data register nor produces events.
- R8: A read of the data register returns the written data bit for output lines and the synchronized, buffered pad value for input lines.
- R9: A pad change appears in the data register after the second rising clock edge and in the event register after the third.
- R10: When an edge and a write-1-clear reach the same event bit in the same cycle, the bit ends up set.
- R11: After reset every register reads 0, pad_oe, pad_out and pad_od are 0, and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_wr_en | input | 1 | Write strobe, one register write per cycle |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pad_in | input | 32 | Pad input values, index = line, may be asynchronous |
| pad_out | output | 32 | Pad output values, index = line |
| pad_oe | output | 32 | Pad output enables, index = line |
| pad_od | output | 32 | Open-drain requests, index = line |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume at most one bus write per cycle, since the bus has a single strobe. They also assume pad_in is only observed through the synchronizer, so its timing relative to the clock does not matter. The stimulus changes bus signals and pads shortly after a rising edge, so each value is stable for a full cycle. The collision case of R10 is lined up on purpose: the write-1-clear lands on the same edge as a captured falling transition. Random phases add overlapping pad toggles and register writes, including writes to unmapped and misaligned addresses.

// File: rtl/gpio_edge_pkg.sv
`timescale 1ns/1ps
package gpio_edge_pkg;

  localparam int unsigned REG_IDX_W  = 3;
  localparam int unsigned BYTE_OFS_W = 2;

  // Register slot = byte offset / 4
  typedef enum logic [REG_IDX_W-1:0] {
    RIDX_DIR  = 3'd0,
    RIDX_ODE  = 3'd1,
    RIDX_DAT  = 3'd2,
    RIDX_EVT  = 3'd3,
    RIDX_MSK  = 3'd4,
    RIDX_CTL  = 3'd5,
    RIDX_IBE  = 3'd6,
    RIDX_NONE = 3'd7
  } reg_idx_e;

  localparam int unsigned REG_COUNT = 7;

endpackage

// File: rtl/gpio_rst_sync.sv
`timescale 1ns/1ps
module gpio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_s_n = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
module gpio_in_sync #(
  parameter int unsigned LINES  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] pad_in,
  input  logic [LINES-1:0] buf_en,
  output logic [LINES-1:0] pin_val,
  output logic [LINES-1:0] rise,
  output logic [LINES-1:0] fall
);

  logic [STAGES-1:0][LINES-1:0] stage_q;
  logic [STAGES-1:0][LINES-1:0] stage_d;
  logic [LINES-1:0]             held_q;
  logic [LINES-1:0]             held_d;
  logic [LINES-1:0]             gated;

  // Next state: shift the pad sample through the chain
  always_comb begin
    stage_d = {stage_q[STAGES-2:0], pad_in};
    gated   = stage_q[STAGES-1] & buf_en;
    held_d  = gated;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      held_q  <= '0;
    end else begin
      stage_q <= stage_d;
      held_q  <= held_d;
    end
  end

  assign pin_val = gated;
  assign rise    = gated & ~held_q;
  assign fall    = ~gated & held_q;

endmodule

// File: rtl/gpio_regbank.sv
`timescale 1ns/1ps
module gpio_regbank
  import gpio_edge_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  reg_idx_e wr_idx,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] ode_q,
  output logic [W-1:0] dat_q,
  output logic [W-1:0] msk_q,
  output logic [W-1:0] ctl_q,
  output logic [W-1:0] ibe_q
);

  logic [W-1:0] dir_d, ode_d, dat_d, msk_d, ctl_d, ibe_d;
  logic         dir_ce, ode_ce, dat_ce, msk_ce, ctl_ce, ibe_ce;

  always_comb begin
    dir_ce = wr_en && (wr_idx == RIDX_DIR);
    ode_ce = wr_en && (wr_idx == RIDX_ODE);
    dat_ce = wr_en && (wr_idx == RIDX_DAT);
    msk_ce = wr_en && (wr_idx == RIDX_MSK);
    ctl_ce = wr_en && (wr_idx == RIDX_CTL);
    ibe_ce = wr_en && (wr_idx == RIDX_IBE);
    dir_d  = dir_ce ? wdata : dir_q;
    ode_d  = ode_ce ? wdata : ode_q;
    dat_d  = dat_ce ? wdata : dat_q;
    msk_d  = msk_ce ? wdata : msk_q;
    ctl_d  = ctl_ce ? wdata : ctl_q;
    ibe_d  = ibe_ce ? wdata : ibe_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      ode_q <= '0;
      dat_q <= '0;
      msk_q <= '0;
      ctl_q <= '0;
      ibe_q <= '0;
    end else begin
      dir_q <= dir_d;
      ode_q <= ode_d;
      dat_q <= dat_d;
      msk_q <= msk_d;
      ctl_q <= ctl_d;
      ibe_q <= ibe_d;
    end
  end

endmodule

// File: rtl/gpio_evt_latch.sv
`timescale 1ns/1ps
module gpio_evt_latch #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_en,
  input  logic [W-1:0] clr_bits,
  input  logic [W-1:0] rise,
  input  logic [W-1:0] fall,
  input  logic [W-1:0] fall_only,
  output logic [W-1:0] evt_q,
  output logic [W-1:0] set_bits
);

  logic [W-1:0] kept;
  logic [W-1:0] evt_d;

  // A fresh capture is ORed in after the clear, so it survives a collision
  always_comb begin
    set_bits = fall | (rise & ~fall_only);
    kept     = clr_en ? (evt_q & ~clr_bits) : evt_q;
    evt_d    = kept | set_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= '0;
    end else begin
      evt_q <= evt_d;
    end
  end

endmodule

// File: rtl/gpio_edge_ctrl.sv
`timescale 1ns/1ps
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int unsigned LINES       = 32,
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [LINES-1:0]  bus_wdata,
  output logic [LINES-1:0]  bus_rdata,
  input  logic [LINES-1:0]  pad_in,
  output logic [LINES-1:0]  pad_out,
  output logic [LINES-1:0]  pad_oe,
  output logic [LINES-1:0]  pad_od,
  output logic              irq
);

  localparam int unsigned WORD_W = ADDR_W - BYTE_OFS_W;

  logic              rst_s_n;
  logic [WORD_W-1:0] word_sel;
  logic              addr_ok;
  reg_idx_e          reg_sel;
  logic              evt_clr;

  logic [LINES-1:0] dir_r, ode_r, dat_r, msk_r, ctl_r, ibe_r, evt_r;
  logic [LINES-1:0] ibe_l, buf_l, rise_l, fall_l;
  logic [LINES-1:0] buf_r, rise_r, fall_r, set_r;

  gpio_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  // Address decode
  always_comb begin
    word_sel = bus_addr[ADDR_W-1:BYTE_OFS_W];
    addr_ok  = (bus_addr[BYTE_OFS_W-1:0] == '0) &&
               (word_sel < WORD_W'(REG_COUNT));
    reg_sel  = addr_ok ? reg_idx_e'(word_sel[REG_IDX_W-1:0]) : RIDX_NONE;
    evt_clr  = bus_wr_en && (reg_sel == RIDX_EVT);
  end

  gpio_regbank #(.W(LINES)) u_regs (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .wr_en  (bus_wr_en),
    .wr_idx (reg_sel),
    .wdata  (bus_wdata),
    .dir_q  (dir_r),
    .ode_q  (ode_r),
    .dat_q  (dat_r),
    .msk_q  (msk_r),
    .ctl_q  (ctl_r),
    .ibe_q  (ibe_r)
  );

  // Line index n <-> register bit LINES-1-n
  for (genvar n = 0; n < LINES; n++) begin : g_swap
    assign ibe_l[n]              = ibe_r[LINES-1-n];
    assign buf_r[LINES-1-n]      = buf_l[n];
    assign rise_r[LINES-1-n]     = rise_l[n];
    assign fall_r[LINES-1-n]     = fall_l[n];
    assign pad_out[n]            = dat_r[LINES-1-n];
    assign pad_oe[n]             = dir_r[LINES-1-n];
    assign pad_od[n]             = ode_r[LINES-1-n];
  end

  gpio_in_sync #(.LINES(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .pad_in  (pad_in),
    .buf_en  (ibe_l),
    .pin_val (buf_l),
    .rise    (rise_l),
    .fall    (fall_l)
  );

  gpio_evt_latch #(.W(LINES)) u_evt (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .clr_en    (evt_clr),
    .clr_bits  (bus_wdata),
    .rise      (rise_r),
    .fall      (fall_r),
    .fall_only (ctl_r),
    .evt_q     (evt_r),
    .set_bits  (set_r)
  );

  // Read mux
  always_comb begin
    unique case (reg_sel)
      RIDX_DIR: bus_rdata = dir_r;
      RIDX_ODE: bus_rdata = ode_r;
      RIDX_DAT: bus_rdata = (dat_r & dir_r) | (buf_r & ~dir_r);
      RIDX_EVT: bus_rdata = evt_r;
      RIDX_MSK: bus_rdata = msk_r;
      RIDX_CTL: bus_rdata = ctl_r;
      RIDX_IBE: bus_rdata = ibe_r;
      default:  bus_rdata = '0;
    endcase
  end

  assign irq = |(evt_r & msk_r);

endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
`timescale 1ns/1ps
module gpio_edge_ctrl_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst_s_n,
  input logic         evt_clr,
  input logic [W-1:0] wdata,
  input logic [W-1:0] evt,
  input logic [W-1:0] msk,
  input logic [W-1:0] ctl,
  input logic [W-1:0] set_bits,
  input logic [W-1:0] fall_bits,
  input logic         irq
);

  assert_w1c_R4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (evt_clr && set_bits == '0) |=> (evt == ($past(evt) & ~$past(wdata))));

  assert_edge_wins_R10: assert property (@(posedge clk) disable iff (!rst_s_n)
    evt_clr |=> ((evt & $past(set_bits)) == $past(set_bits)));

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_s_n)
    !evt_clr |=> ((evt & $past(evt)) == $past(evt)));

  assert_fall_only_R6: assert property (@(posedge clk) disable iff (!rst_s_n)
    $past(rst_s_n) |-> ((evt & ~$past(evt) & $past(ctl) & ~$past(fall_bits)) == '0));

  assert_masked_quiet_R5: assert property (@(posedge clk) disable iff (!rst_s_n)
    (msk == '0) |-> !irq);

  assert_pending_irq_R5: assert property (@(posedge clk) disable iff (!rst_s_n)
    ((evt & msk) != '0) |-> irq);

endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(.W(LINES)) u_chk (
  .clk       (clk),
  .rst_s_n   (rst_s_n),
  .evt_clr   (evt_clr),
  .wdata     (bus_wdata),
  .evt       (evt_r),
  .msk       (msk_r),
  .ctl       (ctl_r),
  .set_bits  (set_r),
  .fall_bits (fall_r),
  .irq       (irq)
);

// File: tb/gpio_edge_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_edge_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr_en;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in;
  logic [31:0] pad_out, pad_oe, pad_od;
  logic        irq;

  int n_cmp  = 0;
  int n_bad  = 0;
  bit cmp_en = 1'b0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  gpio_edge_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_od(pad_od), .irq(irq)
  );

  // ---------------- behavioural reference ----------------
  logic [31:0] m_dir, m_ode, m_dat, m_evt, m_msk, m_ctl, m_ibe;
  logic [31:0] m_pipe[$];   // pad samples in flight, line order
  logic [31:0] m_seen;      // buffered value one cycle ago, line order

  function automatic logic [31:0] flip(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

  function automatic logic [31:0] m_buffered();
    return m_pipe[1] & flip(m_ibe);
  endfunction

  function automatic logic [31:0] m_read(input logic [4:0] a);
    case (a)
      5'h00: return m_dir;
      5'h04: return m_ode;
      5'h08: return (m_dat & m_dir) | (flip(m_buffered()) & ~m_dir);
      5'h0C: return m_evt;
      5'h10: return m_msk;
      5'h14: return m_ctl;
      5'h18: return m_ibe;
      default: return 32'h0;
    endcase
  endfunction

  task automatic m_clear();
    m_dir = '0; m_ode = '0; m_dat = '0; m_evt = '0;
    m_msk = '0; m_ctl = '0; m_ibe = '0; m_seen = '0;
    m_pipe = '{32'h0, 32'h0};
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_clear();
    end else begin
      logic [31:0] now_l, up_l, dn_l, hit_l, nxt_evt;
      now_l = m_buffered();
      up_l  = now_l & ~m_seen;
      dn_l  = ~now_l & m_seen;
      hit_l = dn_l | (up_l & ~flip(m_ctl));
      nxt_evt = m_evt;
      if (bus_wr_en && bus_addr == 5'h0C) nxt_evt = nxt_evt & ~bus_wdata;
      nxt_evt = nxt_evt | flip(hit_l);
      if (bus_wr_en) begin
        case (bus_addr)
          5'h00: m_dir = bus_wdata;
          5'h04: m_ode = bus_wdata;
          5'h08: m_dat = bus_wdata;
          5'h10: m_msk = bus_wdata;
          5'h14: m_ctl = bus_wdata;
          5'h18: m_ibe = bus_wdata;
          default: ;
        endcase
      end
      m_evt  = nxt_evt;
      m_seen = now_l;
      void'(m_pipe.pop_back());
      m_pipe.push_front(pad_in);
    end
  end

  // ---------------- checking ----------------
  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string rd_req(input logic [4:0] a);
    case (a)
      5'h08:   return "R8";
      5'h0C:   return "R4";
      default: return "R1";
    endcase
  endfunction

  // Every clock: compare all outputs with the reference
  always @(negedge clk) begin
    if (cmp_en && rst_n) begin
      check("R5", "irq", {31'h0, irq}, {31'h0, |(m_evt & m_msk)});
      check("R3", "pad_oe", pad_oe, flip(m_dir));
      check("R2", "pad_out", pad_out, flip(m_dat));
      check("R2", "pad_od", pad_od, flip(m_ode));
      check(rd_req(bus_addr), "rdata", bus_rdata, m_read(bus_addr));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a; #1;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  // ---------------- scenario ----------------
  initial begin
    logic [31:0] v;
    rst_n = 1'b0; bus_wr_en = 1'b0; bus_addr = '0; bus_wdata = '0; pad_in = '0;
    idle(4);
    rst_n = 1'b1;
    idle(4);
    cmp_en = 1'b1;

    // R11: reset state
    check("R11", "irq after reset", {31'h0, irq}, 32'h0);
    check("R11", "pad_oe after reset", pad_oe, 32'h0);
    for (int a = 0; a < 7; a++) begin
      rd(5'(a * 4), v);
      check("R11", "register after reset", v, 32'h0);
    end

    // R1: read-back and unmapped addresses
    wr(5'h04, 32'h1234_5678); rd(5'h04, v); check("R1", "drive mode", v, 32'h1234_5678);
    wr(5'h10, 32'h00FF_00F0); rd(5'h10, v); check("R1", "mask", v, 32'h00FF_00F0);
    wr(5'h14, 32'hC3C3_3C3C); rd(5'h14, v); check("R1", "control", v, 32'hC3C3_3C3C);
    wr(5'h1C, 32'hFFFF_FFFF); rd(5'h1C, v); check("R1", "unmapped", v, 32'h0);
    wr(5'h12, 32'hFFFF_FFFF); rd(5'h10, v); check("R1", "misaligned write", v, 32'h00FF_00F0);
    rd(5'h16, v); check("R1", "misaligned read", v, 32'h0);

    // R2/R3: line 0 is register bit 31
    wr(5'h00, 32'h8000_0001);
    wr(5'h08, 32'h8000_0000);
    check("R3", "line0 oe", {31'h0, pad_oe[0]}, 32'h1);
    check("R3", "line31 oe", {31'h0, pad_oe[31]}, 32'h1);
    check("R2", "line0 out", {31'h0, pad_out[0]}, 32'h1);
    check("R2", "line31 out", {31'h0, pad_out[31]}, 32'h0);
    check("R2", "line3 od", {31'h0, pad_od[3]}, 32'h1);

    // R8: outputs read shadow, inputs read pads
    wr(5'h00, 32'hFFFF_0000);
    wr(5'h08, 32'hA5A5_5A5A);
    wr(5'h18, 32'hFFFF_FFFF);
    pad_in = 32'hFFFF_FFFF;
    idle(3);
    rd(5'h08, v); check("R8", "mixed data", v, 32'hA5A5_FFFF);

    // R7: buffer disabled blocks inputs
    wr(5'h18, 32'h0000_0000);
    idle(1);
    rd(5'h08, v); check("R7", "buffer off", v, 32'hA5A5_0000);

    // Quiet baseline for edge tests
    pad_in = '0;
    wr(5'h00, 32'h0);
    wr(5'h18, 32'hFFFF_FFFF);
    wr(5'h14, 32'h0800_0000);        // line 4 falling-only
    wr(5'h10, 32'hFFFF_FFFF);
    idle(4);
    wr(5'h0C, 32'hFFFF_FFFF);
    rd(5'h0C, v); check("R4", "cleared baseline", v, 32'h0);

    // R9 and R6: line 6 any edge, line 4 falling only
    pad_in[4] = 1'b1; pad_in[6] = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    rd(5'h08, v); check("R9", "data after 2 edges", v, 32'h0A00_0000);
    rd(5'h0C, v); check("R9", "no event after 2 edges", v, 32'h0);
    @(posedge clk); #1;
    rd(5'h0C, v); check("R9", "event after 3 edges", v, 32'h0200_0000);
    check("R6", "rise ignored on falling-only line", v & 32'h0800_0000, 32'h0);
    check("R5", "irq on masked-in event", {31'h0, irq}, 32'h1);
    pad_in[4] = 1'b0;
    idle(3);
    rd(5'h0C, v); check("R6", "fall captured", v, 32'h0A00_0000);

    // R4: write-1-clear, write-0 keeps
    wr(5'h0C, 32'h0200_0000);
    rd(5'h0C, v); check("R4", "clear one bit", v, 32'h0800_0000);
    wr(5'h0C, 32'h0);
    rd(5'h0C, v); check("R4", "write zero keeps", v, 32'h0800_0000);

    // R5: masking
    wr(5'h10, 32'h0);
    check("R5", "masked irq", {31'h0, irq}, 32'h0);
    wr(5'h10, 32'h0800_0000);
    check("R5", "unmasked irq", {31'h0, irq}, 32'h1);

    // R10: clear and new falling edge on the same edge
    wr(5'h0C, 32'h0800_0000);
    rd(5'h0C, v); check("R4", "cleared line 4", v, 32'h0);
    pad_in[4] = 1'b1;
    idle(4);
    rd(5'h0C, v); check("R6", "second rise ignored", v, 32'h0);
    pad_in[4] = 1'b0;               // captured on the third edge from here
    @(posedge clk); #1;
    wr(5'h0C, 32'h0800_0000);       // write commits on that same edge
    rd(5'h0C, v); check("R10", "edge beats clear", v, 32'h0800_0000);
    wr(5'h0C, 32'h0800_0000);
    rd(5'h0C, v); check("R10", "later clear works", v, 32'h0);

    // Random phase, compared each cycle against the reference
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); #1;
      if ($urandom_range(0, 3) == 0) pad_in = pad_in ^ (32'h1 << $urandom_range(0, 31));
      bus_addr = 5'($urandom_range(0, 7) * 4);
      if ($urandom_range(0, 15) == 0) bus_addr = bus_addr | 5'h1;
      bus_wr_en = ($urandom_range(0, 5) == 0);
      bus_wdata = $urandom();
    end
    @(posedge clk); #1;
    bus_wr_en = 1'b0;
    idle(4);

    done = 1'b1;
    report();
  end

endmodule